// File: doc/BRIEF.md
# Serial Peripheral Master with Programmable Bit Clock

This block moves one 8-bit word out of a serial data output and, at the same time, collects one 8-bit word from a serial data input. The serial clock comes from the system clock through a 7-bit divide setting. A divide setting `d` gives a bit period of `N = d + 1` system clocks when `d` is 3 or more. Settings 0, 1 and 2 all give the shortest period, 4 clocks. When `N` is odd, the two halves of the serial clock cannot be equal. The half at the idle level is always the longer one and always comes first in each bit period.

Software sets polarity, phase, divide setting and a master-enable bit through a small register port. It then pulses `start` with the outgoing word on `txData`. After exactly eight bit periods, `done` pulses for one clock and the received word appears on `rxData`. The received word stays there until the next transfer completes.

In phase-1 mode, each bit goes out at the start of its bit period. The peripheral's bit is captured at the mid-period edge, where the clock leaves its idle level. In phase-0 mode, outgoing bits change at that mid-period edge, and the capture happens at the end-of-period edge, where the clock returns to idle.

Top module: `spiXferMaster`

## Requirements
- R1: After reset every register reads 0, `sclk`, `simo`, `done` and `rxData` are 0, and no transfer is in progress.
- R2: Register map. Address 0 holds polarity at bit 6. Address 1 holds master enable at bit 2 and phase at bit 3. Address 2 holds the divide setting in bits 6:0. Address 3 reads busy at bit 0. All other bits read 0. Writes made while a transfer is busy leave every register unchanged.
- R3: The bit period is `N = d + 1` system clocks for a divide setting `d >= 3`, and 4 system clocks for `d` of 0, 1 or 2.
- R4: Each bit period begins with `ceil(N/2)` clocks at the idle level, followed by `floor(N/2)` clocks at the opposite level. Both halves are equal when `N` is even.
- R5: While no transfer runs, `sclk` rests at the polarity bit. A transfer produces exactly 16 `sclk` transitions.
- R6: With phase 1, bits leave MSB first and `simo` changes only at the start of a bit period. It is therefore stable for the half period before and the half period after the mid-period edge.
- R7: With phase 1, `somi` is captured at the mid-period edge. That edge is rising for polarity 0 and falling for polarity 1.
- R8: With phase 0, `somi` is captured at the end-of-period edge and `simo` advances at the mid-period edge. Bits are MSB first in both directions.
- R9: `done` is high for exactly one clock, on the 8·N-th clock edge after the edge that accepted `start`. `rxData` changes only together with `done` and then holds.
- R10: A `start` pulse during a busy transfer is ignored. The word being sent and the transfer length do not change.
- R11: A `start` pulse is ignored while master enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data (combinational) |
| start | input | 1 | Begin a transfer |
| txData | input | 8 | Word to send, taken when start is accepted |
| rxData | output | 8 | Last received word |
| done | output | 1 | One-clock pulse at end of transfer |
| sclk | output | 1 | Serial clock |
| simo | output | 1 | Serial data out |
| somi | input | 1 | Serial data in |

## Verification
`done` is expected on the 8·N+1-th falling system-clock edge after `start` is raised. The bench counts falling edges from that point and records exactly which one shows `done`. Each `sclk` change happens one register after the divide counter reaches a half boundary. The bench therefore measures each run length in falling edges, at which point the sampled level already reflects that register. The bench plays the peripheral side: it updates `somi` at the falling edge after each capture edge, which leaves at least two clocks before the next capture. It sweeps divide settings 0 to 16 plus 126 and 127 under all four polarity/phase combinations.

// File: rtl/spiXferPkg.sv
package spiXferPkg;

  localparam logic [1:0] ADDR_CFG    = 2'd0;
  localparam logic [1:0] ADDR_CTL    = 2'd1;
  localparam logic [1:0] ADDR_DIV    = 2'd2;
  localparam logic [1:0] ADDR_STATUS = 2'd3;

  localparam int POL_BIT = 6;
  localparam int EN_BIT  = 2;
  localparam int PHA_BIT = 3;

  typedef struct packed {
    logic busy;      // transfer in progress
    logic load;      // start accepted this cycle
    logic midEdge;   // sclk leaves idle level at this edge
    logic endEdge;   // sclk returns to idle level at this edge
    logic shiftOut;  // advance the outgoing bit
    logic sample;    // capture somi
    logic finish;    // last bit period ends
  } xferStrobe_t;

endpackage

// File: rtl/spiXferRegs.sv
module spiXferRegs
  import spiXferPkg::*;
#(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [1:0]       regAddr,
  input  logic [7:0]       regWrData,
  output logic [7:0]       regRdData,
  input  logic             busy,
  output logic             cpol,
  output logic             cpha,
  output logic             masterEn,
  output logic [DIV_W-1:0] divSet
);

  logic wrOk;
  assign wrOk = regWrEn && !busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cpol     <= 1'b0;
      cpha     <= 1'b0;
      masterEn <= 1'b0;
      divSet   <= '0;
    end else if (wrOk) begin
      unique case (regAddr)
        ADDR_CFG: cpol <= regWrData[POL_BIT];
        ADDR_CTL: begin
          masterEn <= regWrData[EN_BIT];
          cpha     <= regWrData[PHA_BIT];
        end
        ADDR_DIV: divSet <= regWrData[DIV_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    regRdData = '0;
    unique case (regAddr)
      ADDR_CFG: regRdData[POL_BIT] = cpol;
      ADDR_CTL: begin
        regRdData[EN_BIT]  = masterEn;
        regRdData[PHA_BIT] = cpha;
      end
      ADDR_DIV: regRdData[DIV_W-1:0] = divSet;
      default:  regRdData[0] = busy;
    endcase
  end

endmodule

// File: rtl/spiXferCtrl.sv
module spiXferCtrl
  import spiXferPkg::*;
#(
  parameter int WORD_W  = 8,
  parameter int DIV_W   = 7,
  parameter int MIN_DIV = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             masterEn,
  input  logic             cpha,
  input  logic [DIV_W-1:0] divSet,
  output xferStrobe_t      strobe
);

  localparam int CNT_W = DIV_W + 1;
  localparam int IDX_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] MIN_N    = CNT_W'(MIN_DIV);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);

  logic             busy;
  logic [CNT_W-1:0] divCnt;
  logic [IDX_W-1:0] bitIdx;
  logic [CNT_W-1:0] brrExt, divN, firstLen, firstLast, divLast;
  logic             load, midEdge, endEdge, lastBit;

  // period and half boundary derived from the divide setting
  always_comb begin
    brrExt    = {1'b0, divSet};
    divN      = (brrExt < (MIN_N - 1'b1)) ? MIN_N : (brrExt + 1'b1);
    firstLen  = (divN + 1'b1) >> 1;
    firstLast = firstLen - 1'b1;
    divLast   = divN - 1'b1;
  end

  assign load    = !busy && start && masterEn;
  assign midEdge = busy && (divCnt == firstLast);
  assign endEdge = busy && (divCnt == divLast);
  assign lastBit = (bitIdx == LAST_IDX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      divCnt <= '0;
      bitIdx <= '0;
    end else if (load) begin
      busy   <= 1'b1;
      divCnt <= '0;
      bitIdx <= '0;
    end else if (busy) begin
      if (endEdge) begin
        divCnt <= '0;
        if (lastBit) busy <= 1'b0;
        else         bitIdx <= bitIdx + 1'b1;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobe.busy    = busy;
    strobe.load    = load;
    strobe.midEdge = midEdge;
    strobe.endEdge = endEdge;
    strobe.finish  = endEdge && lastBit;
    if (cpha) begin
      strobe.shiftOut = endEdge && !lastBit;
      strobe.sample   = midEdge;
    end else begin
      strobe.shiftOut = midEdge && (bitIdx != '0);
      strobe.sample   = endEdge;
    end
  end

endmodule

// File: rtl/spiXferDatapath.sv
module spiXferDatapath
  import spiXferPkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  xferStrobe_t       strobe,
  input  logic              cpol,
  input  logic [WORD_W-1:0] txData,
  input  logic              somi,
  output logic              sclk,
  output logic              simo,
  output logic [WORD_W-1:0] rxData,
  output logic              done
);

  logic [WORD_W-1:0] txShift, rxShift, rxNext;

  assign rxNext = {rxShift[WORD_W-2:0], somi};
  assign simo   = txShift[WORD_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclk <= 1'b0;
    end else if (strobe.load || !strobe.busy) begin
      sclk <= cpol;
    end else if (strobe.midEdge) begin
      sclk <= ~cpol;
    end else if (strobe.endEdge) begin
      sclk <= cpol;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
    end else if (strobe.load) begin
      txShift <= txData;
    end else if (strobe.shiftOut) begin
      txShift <= {txShift[WORD_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      rxData  <= '0;
      done    <= 1'b0;
    end else begin
      if (strobe.sample) rxShift <= rxNext;
      if (strobe.finish) rxData <= strobe.sample ? rxNext : rxShift;
      done <= strobe.finish;
    end
  end

endmodule

// File: rtl/spiXferMaster.sv
module spiXferMaster
  import spiXferPkg::*;
#(
  parameter int WORD_W  = 8,
  parameter int DIV_W   = 7,
  parameter int MIN_DIV = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic              start,
  input  logic [WORD_W-1:0] txData,
  output logic [WORD_W-1:0] rxData,
  output logic              done,
  output logic              sclk,
  output logic              simo,
  input  logic              somi
);

  xferStrobe_t      strobe;
  logic             busy, cpol, cpha, masterEn;
  logic [DIV_W-1:0] divSet;

  assign busy = strobe.busy;

  spiXferRegs #(.DIV_W(DIV_W)) u_regs (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .busy(busy),
    .cpol(cpol), .cpha(cpha), .masterEn(masterEn), .divSet(divSet)
  );

  spiXferCtrl #(.WORD_W(WORD_W), .DIV_W(DIV_W), .MIN_DIV(MIN_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .masterEn(masterEn),
    .cpha(cpha), .divSet(divSet), .strobe(strobe)
  );

  spiXferDatapath #(.WORD_W(WORD_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cpol(cpol), .txData(txData),
    .somi(somi), .sclk(sclk), .simo(simo), .rxData(rxData), .done(done)
  );

endmodule

// File: rtl/spiXferChecker.sv
module spiXferChecker #(
  parameter int WORD_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              cpol,
  input logic              cpha,
  input logic              sclk,
  input logic              simo,
  input logic              done,
  input logic [WORD_W-1:0] rxData
);

  assert_idle_level_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && $past(!busy) && $stable(cpol)) |-> (sclk == cpol));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_rx_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(rxData));

  assert_busy_end_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  assert_simo_steady_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cpha && !$stable(sclk) && (sclk != cpol)) |-> $stable(simo));

  assert_min_half_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !$stable(sclk)) |=> $stable(sclk));

endmodule

bind spiXferMaster spiXferChecker #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .cpol(cpol), .cpha(cpha),
  .sclk(sclk), .simo(simo), .done(done), .rxData(rxData)
);

// File: tb/spiXferMaster_bench.sv
module spiXferMaster_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWrData = 8'd0;
  logic [7:0] regRdData;
  logic       start = 1'b0;
  logic [7:0] txData = 8'd0;
  logic [7:0] rxData;
  logic       done, sclk, simo;
  logic       somi = 1'b0;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  spiXferMaster u_spiXferMaster (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .start(start),
    .txData(txData), .rxData(rxData), .done(done), .sclk(sclk),
    .simo(simo), .somi(somi)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected<=150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regExpect(input logic [1:0] a, input logic [7:0] e, input string req);
    regAddr = a;
    #0.1;
    check(regRdData == e, req, "register read", regRdData, e);
  endtask

  // mode 0: plain, 1: extra start while busy, 2: register write while busy
  task automatic runXfer(input bit pol, input bit pha, input int brr,
                         input logic [7:0] tx, input logic [7:0] slv, input int mode);
    int n, h1, h2, len, runs, k, doneAt, sumFirst, expLen;
    bit prev, isSample;
    logic [7:0] cap;
    n  = (brr < 3) ? 4 : brr + 1;
    h1 = (n + 1) / 2;
    h2 = n / 2;
    regWrite(2'd0, pol ? 8'h40 : 8'h00);
    regWrite(2'd1, 8'h04 | (pha ? 8'h08 : 8'h00));
    regWrite(2'd2, 8'(brr));
    @(negedge clk);
    check(sclk == pol, "R5", "idle level", sclk, pol);
    somi = slv[7]; txData = tx; start = 1'b1;
    prev = pol; len = 0; runs = 0; k = 0; doneAt = 0; sumFirst = 0; cap = '0;
    for (int i = 1; i <= 8 * n + 4; i++) begin
      @(negedge clk);
      if (i == 1) start = 1'b0;
      if (mode == 1 && i == 3) begin start = 1'b1; txData = ~tx; end
      if (mode == 1 && i == 4) start = 1'b0;
      if (mode == 2 && i == 3) begin
        regWrEn = 1'b1; regAddr = 2'd2; regWrData = 8'((brr ^ 1) & 8'h7f);
      end
      if (mode == 2 && i == 4) begin regWrEn = 1'b0; regAddr = 2'd3; end
      if (mode == 2 && i == 5) check(regRdData == 8'h01, "R2", "busy status", regRdData, 1);
      if (sclk != prev) begin
        runs++;
        expLen = (prev == pol) ? h1 : h2;
        check(len == expLen, "R4", "half length", len, expLen);
        if (runs <= 2) sumFirst += len;
        isSample = pha ? (prev == pol) : (prev != pol);
        if (isSample) begin
          cap = {cap[6:0], simo};
          k++;
          if (k < 8) somi = slv[7 - k];
        end
        prev = sclk; len = 1;
      end else begin
        len++;
      end
      if (done && doneAt == 0) doneAt = i;
    end
    check(doneAt == 8 * n + 1, "R9", "done position", doneAt, 8 * n + 1);
    check(sumFirst == n, "R3", "bit period", sumFirst, n);
    check(runs == 16, "R5", "sclk transitions", runs, 16);
    check(done == 1'b0, "R9", "done dropped", done, 0);
    if (pha) begin
      check(cap == tx, mode == 1 ? "R10" : "R6", "simo word", cap, tx);
      check(rxData == slv, "R7", "received word", rxData, slv);
    end else begin
      check(cap == tx, mode == 1 ? "R10" : "R8", "simo word", cap, tx);
      check(rxData == slv, "R8", "received word", rxData, slv);
    end
    if (mode == 2) regExpect(2'd2, 8'(brr), "R2");
  endtask

  initial begin
    int seen;
    logic [7:0] tx;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(sclk == 1'b0 && simo == 1'b0 && done == 1'b0, "R1", "outputs", {sclk, simo, done}, 0);
    check(rxData == 8'h00, "R1", "rxData", rxData, 0);
    regExpect(2'd0, 8'h00, "R1");
    regExpect(2'd3, 8'h00, "R1");
    rstN = 1'b1;
    @(negedge clk);
    regExpect(2'd1, 8'h00, "R1");
    regExpect(2'd2, 8'h00, "R1");
    // R2 field placement
    regWrite(2'd0, 8'hff); regExpect(2'd0, 8'h40, "R2");
    regWrite(2'd1, 8'hff); regExpect(2'd1, 8'h0c, "R2");
    regWrite(2'd2, 8'hff); regExpect(2'd2, 8'h7f, "R2");
    // R11 start ignored with master enable clear
    regWrite(2'd1, 8'h08);
    regWrite(2'd2, 8'h00);
    regWrite(2'd0, 8'h00);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    seen = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (done || sclk) seen++;
    end
    check(seen == 0, "R11", "activity without enable", seen, 0);
    regExpect(2'd3, 8'h00, "R11");
    // sweep of divide settings, polarity and phase
    for (int b = 0; b <= 16; b++) begin
      for (int c = 0; c < 4; c++) begin
        tx = 8'(8'ha5 ^ (b * 37 + c * 11));
        runXfer(c[0], c[1], b, tx, {tx[3:0], ~tx[7:4]}, 0);
      end
    end
    for (int c = 0; c < 4; c++) begin
      runXfer(c[0], c[1], 127, 8'hff, 8'h00, 0);
      runXfer(c[0], c[1], 126, 8'h00, 8'hff, 0);
    end
    runXfer(1'b0, 1'b1, 5, 8'h3c, 8'hc3, 1);
    runXfer(1'b1, 1'b0, 6, 8'h81, 8'h7e, 1);
    runXfer(1'b0, 1'b1, 9, 8'h5a, 8'h96, 2);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule